// File: doc/BRIEF.md
# Comparator On-Time Retune Controller

This block is a small digital helper beside a low-power relaxation oscillator. The oscillator's precision comparator is powered only while a coarse detector output sits low. The controller measures how long that powered window lasts and nudges a trip-point tuning code so the window gets shorter. A measurement is started by a single retune request. It then counts pulses of a fast count clock across exactly one full low window of the detector, brings the frozen count into the controller domain, compares it with two thresholds, and steps the tuning code by at most one position.

The controller clock is meant to be gated outside the block. The enable output rises with the request and stays high only until the sequence is complete, so nothing clocks between retunes. The tuning code is applied only while the detector level is high, which is the comparator-off phase, so that the analog trip point never moves during a comparison. Requests may arrive at any interval. A request that arrives while a retune is in progress is dropped.

Top module: `tonr_retune_ctrl`

## Requirements
- R1: After reset, tune_code equals RST_CODE (default 1), and busy, done and ctl_clk_en are all 0.
- R2: ctl_clk_en is high whenever retune_req or busy is high, and low otherwise. Between retunes it is therefore low.
- R3: The measured count is the number of cnt_clk rising edges during one full low window of coarse_lvl. Only a low window that begins after the detector has been seen high following the request is counted. A low period already in progress when the request arrives is ignored, and later windows in the same retune are ignored too.
- R4: The count is CNT_W (default 8) bits wide and saturates at 255 instead of wrapping. It is cleared at the start of each retune.
- R5: If the count is greater than TH_HI (default 64), tune_code rises by one, saturating at NUM_SET-1 (default 2).
- R6: If the count is less than TH_LO (default 32), tune_code falls by one, saturating at 0.
- R7: A count from TH_LO to TH_HI inclusive leaves tune_code unchanged.
- R8: tune_code changes only while the synchronised coarse_lvl is high. If the detector is low when the update is due, the controller stays busy and waits.
- R9: A retune_req that arrives while busy is high has no effect. Each accepted request produces exactly one measurement and at most one code step.
- R10: done is a one-cycle pulse in the cycle in which busy falls, once for every completed retune.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Controller clock (gated externally by ctl_clk_en) |
| cnt_clk | input | 1 | Fast count clock from the ring oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| retune_req | input | 1 | Retune start request, controller domain |
| coarse_lvl | input | 1 | Asynchronous coarse detector level; low means comparator on |
| tune_code | output | CODE_W | Trip-point tuning setting, 0 to NUM_SET-1 |
| ctl_clk_en | output | 1 | Request for the controller clock |
| busy | output | 1 | Retune sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The main function is driven with single low windows of exact count-clock lengths. Lengths well above and well below the thresholds separate stepping up from stepping down, and repeating them at the ends of the range exposes any missing saturation. Counts of exactly 32, 48 and 64 check that the comparisons are inclusive, and 65 checks the first value past the upper threshold. A window of 300 edges tells saturation apart from wrapping, because a wrapped count of 44 would leave the code alone. A request made while the detector is already low, a second request issued while busy, and a detector that falls again before the update is applied tell apart partial-window counting, re-triggering and updates made during the comparator-on phase.

// File: rtl/tonr_pkg.sv
package tonr_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ARM    = 2'd1,
      ST_DRAIN  = 2'd2,
      ST_UPDATE = 2'd3
   } tonr_state_e;
endpackage

// File: rtl/tonr_sync.sv
module tonr_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tonr_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[i] <= '0;
         else if (i == 0) stg[i] <= d;
         else stg[i] <= stg[(i > 0) ? i-1 : 0];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/tonr_window_counter.sv
module tonr_window_counter #(
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic             cnt_clk,
   input  logic             rst_n,
   input  logic             arm_s,
   input  logic             det_s,
   output logic [CNT_W-1:0] count,
   output logic             fin
);
   logic arm_d, hi_seen, in_win;
   logic [CNT_W-1:0] count_inc;

   if (SATURATE) begin : g_sat
      assign count_inc = (count == '1) ? count : count + 1'b1;
   end else begin : g_wrap
      assign count_inc = count + 1'b1;
   end

   always_ff @(posedge cnt_clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_d   <= 1'b0;
         hi_seen <= 1'b0;
         in_win  <= 1'b0;
         fin     <= 1'b0;
         count   <= '0;
      end else begin
         arm_d <= arm_s;
         if (!arm_s) begin
            hi_seen <= 1'b0;
            in_win  <= 1'b0;
            fin     <= 1'b0;
         end else if (!arm_d) begin
            count   <= '0;
            hi_seen <= 1'b0;
         end else if (!fin) begin
            if (!hi_seen) begin
               hi_seen <= det_s;
            end else if (!det_s) begin
               in_win <= 1'b1;
               count  <= count_inc;
            end else if (in_win) begin
               fin <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/tonr_code_step.sv
module tonr_code_step #(
   parameter int NUM_SET = 3,
   parameter int CODE_W  = 2,
   parameter int CNT_W   = 8,
   parameter int TH_LO   = 32,
   parameter int TH_HI   = 64
) (
   input  logic [CODE_W-1:0] cur,
   input  logic [CNT_W-1:0]  meas,
   output logic [CODE_W-1:0] nxt
);
   localparam logic [CODE_W-1:0] CODE_MAX = CODE_W'(NUM_SET - 1);
   localparam logic [CNT_W-1:0]  LO_V     = CNT_W'(TH_LO);
   localparam logic [CNT_W-1:0]  HI_V     = CNT_W'(TH_HI);

   always_comb begin
      nxt = cur;
      if (meas > HI_V) begin
         if (cur < CODE_MAX) nxt = cur + 1'b1;
      end else if (meas < LO_V) begin
         if (cur != '0) nxt = cur - 1'b1;
      end
   end
endmodule

// File: rtl/tonr_retune_ctrl.sv
module tonr_retune_ctrl
   import tonr_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter int NUM_SET   = 3,
   parameter int TH_LO     = 32,
   parameter int TH_HI     = 64,
   parameter int RST_CODE  = 1,
   parameter int SYNC_STG  = 2,
   parameter bit SATURATE  = 1'b1,
   localparam int CODE_W   = (NUM_SET > 2) ? $clog2(NUM_SET) : 1
) (
   input  logic              ctl_clk,
   input  logic              cnt_clk,
   input  logic              rst_n,
   input  logic              retune_req,
   input  logic              coarse_lvl,
   output logic [CODE_W-1:0] tune_code,
   output logic              ctl_clk_en,
   output logic              busy,
   output logic              done
);
   if (TH_LO >= TH_HI) begin : g_bad_th
      $error("tonr_retune_ctrl: TH_LO must be below TH_HI");
   end
   if (TH_HI >= (1 << CNT_W)) begin : g_bad_hi
      $error("tonr_retune_ctrl: TH_HI must fit in CNT_W bits");
   end
   if (NUM_SET < 2 || RST_CODE >= NUM_SET) begin : g_bad_set
      $error("tonr_retune_ctrl: bad NUM_SET or RST_CODE");
   end

   tonr_state_e      state;
   logic             arm, arm_s, det_s, det_c, fin, fin_c;
   logic [CNT_W-1:0] cnt_q, lat_q;
   logic [CODE_W-1:0] code_nxt;

   // count clock domain
   tonr_sync #(.W(2), .STAGES(SYNC_STG)) u_sync_cnt (
      .clk(cnt_clk), .rst_n(rst_n), .d({arm, coarse_lvl}), .q({arm_s, det_s})
   );

   tonr_window_counter #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_win (
      .cnt_clk(cnt_clk), .rst_n(rst_n), .arm_s(arm_s), .det_s(det_s),
      .count(cnt_q), .fin(fin)
   );

   // controller clock domain
   tonr_sync #(.W(2), .STAGES(SYNC_STG)) u_sync_ctl (
      .clk(ctl_clk), .rst_n(rst_n), .d({fin, coarse_lvl}), .q({fin_c, det_c})
   );

   tonr_code_step #(
      .NUM_SET(NUM_SET), .CODE_W(CODE_W), .CNT_W(CNT_W),
      .TH_LO(TH_LO), .TH_HI(TH_HI)
   ) u_step (
      .cur(tune_code), .meas(lat_q), .nxt(code_nxt)
   );

   always_ff @(posedge ctl_clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         lat_q     <= '0;
         tune_code <= CODE_W'(RST_CODE);
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE:   if (retune_req) state <= ST_ARM;
            ST_ARM: if (fin_c) begin
               lat_q <= cnt_q;
               state <= ST_DRAIN;
            end
            ST_DRAIN:  if (!fin_c) state <= ST_UPDATE;
            ST_UPDATE: if (det_c) begin
               tune_code <= code_nxt;
               done      <= 1'b1;
               state     <= ST_IDLE;
            end
            default:   state <= ST_IDLE;
         endcase
      end
   end

   assign arm        = (state == ST_ARM);
   assign busy       = (state != ST_IDLE);
   assign ctl_clk_en = busy | retune_req;
endmodule

// File: rtl/tonr_retune_chk.sv
module tonr_retune_chk #(
   parameter int CNT_W  = 8,
   parameter int CODE_W = 2,
   parameter int NUM_SET = 3
) (
   input logic              ctl_clk,
   input logic              cnt_clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              ctl_clk_en,
   input logic              det_c,
   input logic [CODE_W-1:0] tune_code,
   input logic [CNT_W-1:0]  cnt_q
);
   AST_EN_COVERS_BUSY: assert property (@(posedge ctl_clk) disable iff (!rst_n)
      busy |-> ctl_clk_en); // R2
   AST_CODE_IN_RANGE: assert property (@(posedge ctl_clk) disable iff (!rst_n)
      int'(tune_code) < NUM_SET); // R5
   AST_CODE_ONE_STEP: assert property (@(posedge ctl_clk) disable iff (!rst_n)
      (tune_code != $past(tune_code)) |->
         (tune_code == $past(tune_code) + 1'b1 || tune_code == $past(tune_code) - 1'b1)); // R6
   AST_CODE_WHEN_OFF: assert property (@(posedge ctl_clk) disable iff (!rst_n)
      (tune_code != $past(tune_code)) |-> ($past(det_c) && done)); // R8
   AST_DONE_ONE_CYCLE: assert property (@(posedge ctl_clk) disable iff (!rst_n)
      done |=> !done); // R10
   AST_DONE_ENDS_BUSY: assert property (@(posedge ctl_clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy))); // R10
   AST_NO_OVERFLOW: assert property (@(posedge cnt_clk) disable iff (!rst_n)
      (&cnt_q) |=> ((&cnt_q) || cnt_q == '0)); // R4
endmodule

bind tonr_retune_ctrl tonr_retune_chk #(
   .CNT_W(CNT_W), .CODE_W(CODE_W), .NUM_SET(NUM_SET)
) u_chk (
   .ctl_clk(ctl_clk), .cnt_clk(cnt_clk), .rst_n(rst_n), .busy(busy),
   .done(done), .ctl_clk_en(ctl_clk_en), .det_c(det_c),
   .tune_code(tune_code), .cnt_q(cnt_q)
);

// File: tb/tonr_retune_ctrl_tb.sv
`timescale 1ns/1ps
module tonr_retune_ctrl_tb;
   logic ctl_clk = 1'b0, cnt_clk = 1'b0, rst_n = 1'b0;
   logic retune_req = 1'b0, coarse_lvl = 1'b1;
   logic [1:0] tune_code;
   logic ctl_clk_en, busy, done;
   int n_chk = 0, n_bad = 0, n_done = 0;
   bit  finished = 1'b0;

   always #2.5 ctl_clk = ~ctl_clk;
   always #2.0 cnt_clk = ~cnt_clk;

   tonr_retune_ctrl u_dut (
      .ctl_clk(ctl_clk), .cnt_clk(cnt_clk), .rst_n(rst_n),
      .retune_req(retune_req), .coarse_lvl(coarse_lvl),
      .tune_code(tune_code), .ctl_clk_en(ctl_clk_en), .busy(busy), .done(done)
   );

   always @(negedge ctl_clk) if (done) n_done++;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic pulse_req();
      @(negedge ctl_clk) retune_req = 1'b1;
      @(negedge ctl_clk) retune_req = 1'b0;
   endtask

   task automatic low_window(input int n);
      @(posedge cnt_clk); #1 coarse_lvl = 1'b0;
      repeat (n) @(posedge cnt_clk);
      #1 coarse_lvl = 1'b1;
   endtask

   task automatic wait_idle();
      int k = 0;
      while (busy && k < 4000) begin @(negedge ctl_clk); k++; end
      if (busy) chk("watchdog busy", 1, 0);
      repeat (4) @(negedge ctl_clk);
   endtask

   // one full retune with a single clean window of n count edges
   task automatic retune(input int n, input int exp_code, input string tag);
      int d0 = n_done;
      coarse_lvl = 1'b1;
      pulse_req();
      repeat (12) @(negedge ctl_clk);
      low_window(n);
      wait_idle();
      chk(tag, int'(tune_code), exp_code);
      chk({tag, " done pulses (R10)"}, n_done - d0, 1);
   endtask

   task automatic t_reset();
      chk("R1 code", int'(tune_code), 1);
      chk("R1 busy", int'(busy), 0);
      chk("R1 done", int'(done), 0);
      chk("R1 clk_en", int'(ctl_clk_en), 0);
   endtask

   task automatic t_clk_en();
      @(negedge ctl_clk) retune_req = 1'b1;
      #1 chk("R2 en with req", int'(ctl_clk_en), 1);
      @(negedge ctl_clk) retune_req = 1'b0;
      chk("R2 en while busy", int'(ctl_clk_en & busy), 1);
      repeat (12) @(negedge ctl_clk);
      low_window(80);
      wait_idle();
      chk("R5 step up", int'(tune_code), 2);
      chk("R2 en low when idle", int'(ctl_clk_en), 0);
   endtask

   task automatic t_partial();
      int d0 = n_done;
      @(negedge ctl_clk) coarse_lvl = 1'b0;
      pulse_req();
      repeat (100) @(posedge cnt_clk);
      #1 coarse_lvl = 1'b1;
      repeat (20) @(posedge cnt_clk);
      low_window(20);
      wait_idle();
      chk("R3 partial low ignored", int'(tune_code), 0);
      chk("R3 done pulses", n_done - d0, 1);
   endtask

   task automatic t_busy_ignore();
      int d0 = n_done;
      pulse_req();
      repeat (6) @(negedge ctl_clk);
      pulse_req();
      repeat (6) @(negedge ctl_clk);
      low_window(80);
      wait_idle();
      repeat (100) @(negedge ctl_clk);
      chk("R9 one step only", int'(tune_code), 1);
      chk("R9 stays idle", int'(busy), 0);
      chk("R9 one completion", n_done - d0, 1);
   endtask

   task automatic t_update_wait();
      pulse_req();
      repeat (12) @(negedge ctl_clk);
      low_window(100);
      #12 coarse_lvl = 1'b0;
      repeat (60) @(negedge ctl_clk);
      chk("R8 held while low: code", int'(tune_code), 1);
      chk("R8 held while low: busy", int'(busy), 1);
      coarse_lvl = 1'b1;
      wait_idle();
      chk("R8 applied when high", int'(tune_code), 2);
   endtask

   initial begin
      repeat (3) @(negedge ctl_clk);
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge ctl_clk);
      t_reset();
      t_clk_en();                                   // 1 -> 2
      retune(100, 2, "R5 saturate high");
      retune(10,  1, "R6 step down");
      retune(10,  0, "R6 step down again");
      retune(10,  0, "R6 saturate low");
      retune(48,  0, "R7 mid count");
      retune(32,  0, "R7 at low threshold");
      retune(65,  1, "R5 just above high");
      retune(64,  1, "R7 at high threshold");
      retune(300, 2, "R4 saturating count");
      retune(10,  1, "R6 down");
      t_partial();                                  // 1 -> 0
      t_busy_ignore();                              // 0 -> 1
      t_update_wait();                              // 1 -> 2
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge ctl_clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule